// File: doc/BRIEF.md
# Scaled PWM Counter and Comparator

This block is the timing core of a PWM channel group. A wide free-running counter advances once per clock while the run bit is set. A `CMP_W`-bit window is taken out of that counter, starting at a bit position set by a 4-bit scale field. Moving the window up by one bit halves the rate at which the windowed value advances, so no separate prescaler counter is needed. The windowed value is the scaled count. It is compared every cycle against each compare register, and each comparison drives one raw match output.

An optional period mode sets the PWM period. When the scaled count equals compare register 0, the counter is cleared one cycle later. Software reaches the block through a plain 32-bit register port. A write takes effect at the clock edge on which `reg_wr` is high. Reads are combinational from `reg_addr`. The port has no data stream, so it has no valid/ready handshake and never applies back-pressure: every access completes in one cycle.

Register layout:
- The control word is at offset 0x00. The scale field is in bits [3:0], the period-mode bit is bit 8 and the run bit is bit 12.
- The scaled count is at offset 0x10.
- Compare register i is at offset 0x20 + 4·i.

Top module: `scaled_pwm_timer`

## Requirements
- R1: After reset the control word, the scaled count and every compare register read 0, and every match output is 1.
- R2: With run set (control bit 12), scale 0 and period mode clear, the scaled count read at 0x10 increases by exactly 1 on every clock.
- R3: With scale value s (control bits [3:0]), the scaled count is counter bits [s+CMP_W-1:s]. With scale 3 it therefore advances once every 8 clocks.
- R4: A write to 0x10 loads `reg_wdata[CMP_W-1:0]` into the counter window selected by the current scale and leaves all other counter bits unchanged.
- R5: Match output i is 1 exactly when the scaled count is greater than or equal to compare register i. It follows every change of either value.
- R6: With period mode (control bit 8) and run set, a cycle in which the scaled count equals compare register 0 is followed by one more increment and then a counter clear. At scale 0 with compare value C, the count runs 0..C+1 and repeats.
- R7: With period mode clear, the counter wraps from all ones to zero on the next increment. The counter is CMP_W+15 bits wide.
- R8: Reserved bits read as 0 and ignore writes: control bits other than [3:0], 8 and 12, and bits above CMP_W-1 of the scaled count and compare registers. Unmapped offsets read 0 and ignore writes.
- R9: Compare registers at 0x20 and 0x24 store `reg_wdata[CMP_W-1:0]` and read it back.
- R10: With run clear and no register write, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, applied at the clock edge |
| reg_addr | input | ADDR_W | Byte offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| cmp_match | output | N_CMP | Raw per-compare match outputs (scaled count ≥ compare value) |

## Verification
The checker watches five things on every cycle:
- The counter steps by exactly one when running.
- The counter holds when stopped.
- The counter clears two cycles after a compare-0 match in period mode.
- Each match output agrees with the scaled count and its compare value.
- Reserved read bits stay zero at the data-register offsets.

Only the bench scenarios can show the rest:
- The window sits at the right bit position and rescales the rate.
- A window write leaves the bits outside the window intact.
- The full-width counter wraps to zero.
- Control reserved bits and unmapped offsets are masked.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int SCALE_W       = 4;
  localparam int ADDR_CTRL     = 'h00;
  localparam int ADDR_SCALED   = 'h10;
  localparam int ADDR_CMP_BASE = 'h20;
  localparam int CTRL_ZERO_BIT = 8;
  localparam int CTRL_RUN_BIT  = 12;

  typedef struct packed {
    logic               run;
    logic               zero_en;
    logic [SCALE_W-1:0] scale;
  } spwm_ctrl_t;
endpackage

// File: rtl/spwm_regs.sv
module spwm_regs
  import spwm_pkg::*;
#(
  parameter int CMP_W  = 16,
  parameter int N_CMP  = 2,
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [31:0]                 reg_wdata,
  input  logic [CMP_W-1:0]            scaled_cnt,
  output logic [31:0]                 reg_rdata,
  output spwm_ctrl_t                  ctrl_q,
  output logic [N_CMP-1:0][CMP_W-1:0] cmp_vals,
  output logic                        ld_scaled,
  output logic [CMP_W-1:0]            ld_val
);
  logic             hit_ctrl, hit_scaled;
  logic [N_CMP-1:0] hit_cmp;

  assign hit_ctrl   = (reg_addr == ADDR_W'(ADDR_CTRL));
  assign hit_scaled = (reg_addr == ADDR_W'(ADDR_SCALED));
  assign ld_scaled  = reg_wr && hit_scaled;
  assign ld_val     = reg_wdata[CMP_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (reg_wr && hit_ctrl) begin
      ctrl_q.scale   <= reg_wdata[SCALE_W-1:0];
      ctrl_q.zero_en <= reg_wdata[CTRL_ZERO_BIT];
      ctrl_q.run     <= reg_wdata[CTRL_RUN_BIT];
    end
  end

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp_reg
    assign hit_cmp[i] = (reg_addr == ADDR_W'(ADDR_CMP_BASE + 4 * i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_vals[i] <= '0;
      else if (reg_wr && hit_cmp[i]) cmp_vals[i] <= reg_wdata[CMP_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_ctrl) begin
      reg_rdata[SCALE_W-1:0]    = ctrl_q.scale;
      reg_rdata[CTRL_ZERO_BIT]  = ctrl_q.zero_en;
      reg_rdata[CTRL_RUN_BIT]   = ctrl_q.run;
    end
    if (hit_scaled) reg_rdata[CMP_W-1:0] = scaled_cnt;
    for (int i = 0; i < N_CMP; i++) begin
      if (hit_cmp[i]) reg_rdata[CMP_W-1:0] = cmp_vals[i];
    end
  end
endmodule

// File: rtl/spwm_counter.sv
module spwm_counter #(
  parameter int CMP_W   = 16,
  parameter int SCALE_W = 4,
  parameter int CNT_W   = CMP_W + (1 << SCALE_W) - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               zero_en,
  input  logic [SCALE_W-1:0] scale,
  input  logic [CMP_W-1:0]   cmp0,
  input  logic               ld_scaled,
  input  logic [CMP_W-1:0]   ld_val,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [CMP_W-1:0]   scaled_cnt,
  output logic               zero_pend
);
  logic [CNT_W-1:0] cnt_nxt;

  assign scaled_cnt = cnt_q[scale +: CMP_W];

  always_comb begin
    cnt_nxt = cnt_q;
    if (ld_scaled)      cnt_nxt[scale +: CMP_W] = ld_val;
    else if (zero_pend) cnt_nxt = '0;
    else if (run)       cnt_nxt = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      zero_pend <= 1'b0;
    end else begin
      cnt_q     <= cnt_nxt;
      zero_pend <= run && zero_en && !ld_scaled && (scaled_cnt == cmp0);
    end
  end
endmodule

// File: rtl/spwm_compare.sv
module spwm_compare #(
  parameter int CMP_W = 16,
  parameter int N_CMP = 2
) (
  input  logic [CMP_W-1:0]            scaled_cnt,
  input  logic [N_CMP-1:0][CMP_W-1:0] cmp_vals,
  output logic [N_CMP-1:0]            cmp_match
);
  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    assign cmp_match[i] = (scaled_cnt >= cmp_vals[i]);
  end
endmodule

// File: rtl/scaled_pwm_timer.sv
module scaled_pwm_timer
  import spwm_pkg::*;
#(
  parameter int CMP_W  = 16,
  parameter int N_CMP  = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [N_CMP-1:0]  cmp_match
);
  localparam int SCALE_MAX = (1 << SCALE_W) - 1;
  localparam int CNT_W     = CMP_W + SCALE_MAX;

  spwm_ctrl_t                  ctrl_q;
  logic [N_CMP-1:0][CMP_W-1:0] cmp_vals;
  logic                        ld_scaled;
  logic [CMP_W-1:0]            ld_val;
  logic [CNT_W-1:0]            cnt_q;
  logic [CMP_W-1:0]            scaled_cnt;
  logic                        zero_pend;

  spwm_regs #(.CMP_W(CMP_W), .N_CMP(N_CMP), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .scaled_cnt(scaled_cnt), .reg_rdata(reg_rdata),
    .ctrl_q(ctrl_q), .cmp_vals(cmp_vals), .ld_scaled(ld_scaled), .ld_val(ld_val)
  );

  spwm_counter #(.CMP_W(CMP_W), .SCALE_W(SCALE_W), .CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .zero_en(ctrl_q.zero_en),
    .scale(ctrl_q.scale), .cmp0(cmp_vals[0]), .ld_scaled(ld_scaled),
    .ld_val(ld_val), .cnt_q(cnt_q), .scaled_cnt(scaled_cnt), .zero_pend(zero_pend)
  );

  spwm_compare #(.CMP_W(CMP_W), .N_CMP(N_CMP)) u_compare (
    .scaled_cnt(scaled_cnt), .cmp_vals(cmp_vals), .cmp_match(cmp_match)
  );
endmodule

// File: rtl/spwm_checker.sv
module spwm_checker
  import spwm_pkg::*;
#(
  parameter int CMP_W  = 16,
  parameter int N_CMP  = 2,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = CMP_W + 15
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        reg_wr,
  input logic [ADDR_W-1:0]           reg_addr,
  input logic [31:0]                 reg_rdata,
  input logic [N_CMP-1:0]            cmp_match,
  input logic                        run_en,
  input logic                        zero_en,
  input logic [CNT_W-1:0]            cnt_q,
  input logic [CMP_W-1:0]            scaled_cnt,
  input logic [N_CMP-1:0][CMP_W-1:0] cmp_vals,
  input logic                        zero_pend
);
  logic data_addr;
  assign data_addr = (reg_addr == ADDR_W'(ADDR_SCALED)) ||
                     (reg_addr == ADDR_W'(ADDR_CMP_BASE)) ||
                     (reg_addr == ADDR_W'(ADDR_CMP_BASE + 4));

  assert_hold_when_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !reg_wr) |=> $stable(cnt_q));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !reg_wr && !zero_pend) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_period_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((run_en && zero_en && !reg_wr && (scaled_cnt == cmp_vals[0])) ##1 !reg_wr)
      |=> (cnt_q == '0));

  assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_addr |-> ((reg_rdata >> CMP_W) == 32'd0));

  for (genvar i = 0; i < N_CMP; i++) begin : g_chk
    assert_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_match[i] == (scaled_cnt >= cmp_vals[i]));
  end
endmodule

bind scaled_pwm_timer spwm_checker #(
  .CMP_W(CMP_W), .N_CMP(N_CMP), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .cmp_match(cmp_match), .run_en(ctrl_q.run),
  .zero_en(ctrl_q.zero_en), .cnt_q(cnt_q), .scaled_cnt(scaled_cnt),
  .cmp_vals(cmp_vals), .zero_pend(zero_pend)
);

// File: tb/scaled_pwm_timer_bench.sv
module scaled_pwm_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  cmp_match;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  scaled_pwm_timer u_scaled_pwm_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_match(cmp_match)
  );

  typedef struct packed {
    logic [7:0]  a;
    logic        we;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'h20, 1'b1, 32'hDEAD1234, 32'h00001234},
    '{8'h24, 1'b1, 32'h0000BEEF, 32'h0000BEEF},
    '{8'h24, 1'b1, 32'hFFFF0001, 32'h00000001},
    '{8'h04, 1'b1, 32'hFFFFFFFF, 32'h00000000},
    '{8'h00, 1'b1, 32'hFFFFEEF5, 32'h00000005},
    '{8'h30, 1'b0, 32'h00000000, 32'h00000000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the following rising edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v, v0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h00, v); check("R1 ctrl", v, 32'h0);
    rd(8'h10, v); check("R1 scaled", v, 32'h0);
    rd(8'h20, v); check("R1 cmp0", v, 32'h0);
    check("R1 match", {30'd0, cmp_match}, 32'h3);

    // R8 / R9 vector table
    for (int i = 0; i < 6; i++) begin
      if (VEC[i].we) wr(VEC[i].a, VEC[i].d);
      rd(VEC[i].a, v);
      check((VEC[i].a >= 8'h20 && VEC[i].a < 8'h28) ? "R8/R9 cmp" : "R8 rsvd", v, VEC[i].e);
    end

    // R2 unit step at scale 0
    wr(8'h00, 32'h1000);
    rd(8'h10, v0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rd(8'h10, v);
      check("R2 step", v, (v0 + 32'd1) & 32'hFFFF);
      v0 = v;
    end

    // R10 hold when stopped
    wr(8'h00, 32'h0000);
    rd(8'h10, v0);
    repeat (5) @(negedge clk);
    rd(8'h10, v);
    check("R10 hold", v, v0);

    // R4 window load keeps other bits
    wr(8'h10, 32'h00001234);
    rd(8'h10, v); check("R4 load s0", v, 32'h1234);
    wr(8'h00, 32'h0004);
    wr(8'h10, 32'hFFFFABCD);
    rd(8'h10, v); check("R4 load s4", v, 32'hABCD);
    wr(8'h00, 32'h0000);
    rd(8'h10, v); check("R4 outside bits", v, 32'hBCD4);

    // R3 scale 3 divides by 8
    wr(8'h10, 32'h0);
    wr(8'h00, 32'h1003);
    rd(8'h10, v0);
    repeat (7) @(negedge clk);
    rd(8'h10, v); check("R3 before tick", v, v0);
    @(negedge clk);
    rd(8'h10, v); check("R3 tick", v, (v0 + 32'd1) & 32'hFFFF);
    repeat (16) @(negedge clk);
    rd(8'h10, v); check("R3 rate", v, (v0 + 32'd3) & 32'hFFFF);

    // R5 compare outputs
    wr(8'h00, 32'h0000);
    wr(8'h20, 32'd100);
    wr(8'h24, 32'd101);
    wr(8'h10, 32'd100);
    #1; check("R5 equal", {30'd0, cmp_match}, 32'h1);
    wr(8'h10, 32'd101);
    #1; check("R5 above", {30'd0, cmp_match}, 32'h3);
    wr(8'h10, 32'd99);
    #1; check("R5 below", {30'd0, cmp_match}, 32'h0);
    wr(8'h20, 32'd0);
    wr(8'h24, 32'd0);
    #1; check("R5 zero cmp", {30'd0, cmp_match}, 32'h3);

    // R6 period reset: 0..C+1 then 0
    wr(8'h10, 32'd0);
    wr(8'h20, 32'd5);
    wr(8'h00, 32'h1100);
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      rd(8'h10, v);
      check("R6 period", v, i % 7);
    end

    // R7 natural wrap of the full counter
    wr(8'h00, 32'h000F);
    wr(8'h10, 32'hFFFF);
    wr(8'h00, 32'h0000);
    wr(8'h10, 32'hFFFF);
    wr(8'h00, 32'h100F);
    rd(8'h10, v); check("R7 all ones", v, 32'hFFFF);
    @(negedge clk);
    rd(8'h10, v); check("R7 wrap", v, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule